// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Replay

This block carries 36-bit words in one direction, from a producer clocked by a write clock to a consumer clocked by a separate read clock. The two clocks run freely and may be unrelated or the same clock. The read port works in first-word-fall-through fashion. The oldest stored word is presented at the output without any request, and a ready flag on the read side says whether that word is valid. A read request only removes the presented word. Each side has its own status. The write side reports whether a word can be accepted and whether free space is running low. The read side reports whether a word is presented and whether the stored count is running low. Each flag is registered in the clock domain of the port that uses it.

The pointers cross between the domains as gray code through multi-stage synchronizers. The status seen on one side therefore lags activity on the other side. A full or empty indication can be late, but it is never early. A replay feature allows words that were already read to be delivered again. The consumer marks the presented word. A later replay command rewinds the read side to that mark. While a mark is held, the storage from the marked word onward stays occupied, so the producer cannot overwrite it. Releasing the mark frees that space.

The depth is a parameter (512 words by default, any power of two such as 1024 or 2048). Both low-water thresholds are held in registers that can be reloaded at run time.

Top module: `dual_clock_fwft_fifo`

## Requirements
- R1: While `rst` is high, `in_ready` and `out_ready` are 0. After reset the empty FIFO shows `in_ready`=1, `out_ready`=0, `almost_empty`=1 and `almost_full`=0, and both thresholds hold DEF_OFFSET (8).
- R2: Words leave in the order they were written. The oldest word is on `rd_data` with `out_ready`=1 and no request. A read-clock edge with `rd_en`=1 and `out_ready`=1 removes it. The presented word holds while nothing removes it.
- R3: `in_ready` is 0 exactly when DEPTH words are occupied. A write with `in_ready`=0 stores nothing, and the occupancy never exceeds DEPTH.
- R4: A read request with `out_ready`=0 removes nothing. The next word written is the one presented later.
- R5: After the pointers settle, `almost_empty` is 1 exactly when the stored word count, including the presented word, is at or below the almost-empty threshold.
- R6: After the pointers settle, `almost_full` is 1 exactly when the free space (DEPTH minus occupied words) is at or below the almost-full threshold.
- R7: `af_load` on a write-clock edge loads `af_value` into the almost-full threshold. `ae_load` on a read-clock edge loads `ae_value` into the almost-empty threshold.
- R8: A pulse on `rt_mark` records the presented word as the mark. A pulse on `rt_go` while a mark is held makes `out_ready` 0 on the next read edge. Delivery then restarts from the marked word, in the original order.
- R9: While a mark is held, every word from the mark up to the newest write counts as occupied for `in_ready` and `almost_full`. A pulse on `rt_free` releases the mark, after which space already read becomes free.
- R10: The pointer codes that cross domains change by at most one bit per edge of their source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| af_load | input | 1 | Load almost-full threshold (write clock) |
| af_value | input | ADDR_W+1 | New almost-full threshold |
| in_ready | output | 1 | A write would be accepted |
| almost_full | output | 1 | Free space at or below its threshold |
| rd_en | input | 1 | Remove the presented word |
| rd_data | output | DATA_W | Presented word |
| out_ready | output | 1 | `rd_data` holds a valid word |
| almost_empty | output | 1 | Stored count at or below its threshold |
| ae_load | input | 1 | Load almost-empty threshold (read clock) |
| ae_value | input | ADDR_W+1 | New almost-empty threshold |
| rt_mark | input | 1 | Record presented word as replay mark |
| rt_go | input | 1 | Rewind delivery to the mark |
| rt_free | input | 1 | Release the replay mark |

## Verification
Write-side results are due at once. `in_ready` and `almost_full` reflect the write pointer on the same write edge that accepts a word. Read-side results (`out_ready`, `rd_data`, `almost_empty`) follow a write after one write edge plus three read edges. Results that depend on the far side's pointer, and the release of a mark, need the synchronizer depth plus up to DEPTH single-step moves of the protection pointer. A replay drops `out_ready` on the first read edge after `rt_go`. The bench drives and samples on falling edges, samples one falling edge after `rt_go` for the replay dip, and waits a fixed window of read cycles (longer after a release) before it compares any cross-domain result.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    localparam int WORD_W     = 36;
    localparam int DEF_DEPTH  = 512;
    localparam int DEF_THRESH = 8;

    // per-side registered status: ready plus the low-water warning
    typedef struct packed {
        logic ready;
        logic almost;
    } side_flags_t;

    // true when the threshold value fits the pointer width used for counts
    function automatic bit thresh_fits(input int thresh, input int ptr_w);
        return thresh < (1 << ptr_w);
    endfunction

endpackage

// File: rtl/xfifo_gray2bin.sv
module xfifo_gray2bin #(
    parameter int W = 5
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // each binary bit is the parity of the gray bits at and above it
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^(gray >> i);
    end
endmodule

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int DW    = 36,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read port doubles as the fall-through output register
    always_ff @(posedge rd_clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xfifo_wr_side.sv
module xfifo_wr_side
    import xfifo_pkg::*;
#(
    parameter int AW      = 9,
    parameter int THRESH0 = 8,
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          af_load,
    input  logic [PW-1:0] af_value,
    input  logic [PW-1:0] prot_gray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] wr_gray,
    output logic [PW-1:0] used,
    output side_flags_t   flags
);
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] wptr, wptr_n, prot_b, used_n, thresh;
    side_flags_t   fl;
    logic          push;

    xfifo_gray2bin #(.W(PW)) u_prot_dec (.gray(prot_gray_s), .bin(prot_b));

    always_comb begin
        push   = wr_en && fl.ready;
        wptr_n = wptr + PW'(push);
        used_n = wptr_n - prot_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            wr_gray  <= '0;
            fl       <= '0;
            thresh   <= PW'(THRESH0);
        end else begin
            wptr     <= wptr_n;
            wr_gray  <= wptr_n ^ (wptr_n >> 1);
            fl.ready <= used_n != DEPTH_P;
            fl.almost <= (DEPTH_P - used_n) <= thresh;
            if (af_load) thresh <= af_value;
        end
    end

    assign mem_we   = push;
    assign mem_addr = wptr[AW-1:0];
    assign used     = wptr - prot_b;
    assign flags    = fl;
endmodule

// File: rtl/xfifo_rd_side.sv
module xfifo_rd_side
    import xfifo_pkg::*;
#(
    parameter int AW      = 9,
    parameter int THRESH0 = 8,
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          rt_mark,
    input  logic          rt_go,
    input  logic          rt_free,
    input  logic          ae_load,
    input  logic [PW-1:0] ae_value,
    input  logic [PW-1:0] wr_gray_s,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] prot_gray,
    output logic          mark_on,
    output side_flags_t   flags
);
    logic [PW-1:0] rptr, rptr_n, wp, head_n, cnt_n;
    logic [PW-1:0] mark, mark_n, prot, prot_n, target, thresh;
    logic          ov, ov_n, mark_on_n, pop, rewind, fetch, ae;

    xfifo_gray2bin #(.W(PW)) u_wr_dec (.gray(wr_gray_s), .bin(wp));

    always_comb begin
        pop    = rd_en && ov;
        rewind = rt_go && mark_on;
        rptr_n = rptr;
        ov_n   = ov;
        fetch  = 1'b0;
        if (rewind) begin
            rptr_n = mark;
            ov_n   = 1'b0;
        end else begin
            if (pop) ov_n = 1'b0;
            if ((!ov || pop) && (rptr != wp)) begin
                fetch  = 1'b1;
                rptr_n = rptr + 1'b1;
                ov_n   = 1'b1;
            end
        end
        // oldest word still owned by the consumer (presented or not yet fetched)
        head_n = rptr_n - PW'(ov_n);
        cnt_n  = wp - head_n;

        mark_on_n = mark_on;
        mark_n    = mark;
        if (rt_mark) begin
            mark_on_n = 1'b1;
            mark_n    = rptr - PW'(ov);
        end else if (rt_free) begin
            mark_on_n = 1'b0;
        end

        // the pointer shown to the writer walks one step per cycle
        target = mark_on_n ? mark_n : head_n;
        prot_n = (prot != target) ? prot + 1'b1 : prot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr      <= '0;
            ov        <= 1'b0;
            ae        <= 1'b1;
            mark      <= '0;
            mark_on   <= 1'b0;
            prot      <= '0;
            prot_gray <= '0;
            thresh    <= PW'(THRESH0);
        end else begin
            rptr      <= rptr_n;
            ov        <= ov_n;
            ae        <= cnt_n <= thresh;
            mark      <= mark_n;
            mark_on   <= mark_on_n;
            prot      <= prot_n;
            prot_gray <= prot_n ^ (prot_n >> 1);
            if (ae_load) thresh <= ae_value;
        end
    end

    assign mem_re       = fetch;
    assign mem_addr     = rptr[AW-1:0];
    assign flags.ready  = ov;
    assign flags.almost = ae;
endmodule

// File: rtl/dual_clock_fwft_fifo.sv
module dual_clock_fwft_fifo
    import xfifo_pkg::*;
#(
    parameter int DATA_W    = WORD_W,
    parameter int DEPTH     = DEF_DEPTH,
    parameter int DEF_OFFSET = DEF_THRESH,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int PW       = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              af_load,
    input  logic [PW-1:0]     af_value,
    output logic              in_ready,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_ready,
    output logic              almost_empty,
    input  logic              ae_load,
    input  logic [PW-1:0]     ae_value,
    input  logic              rt_mark,
    input  logic              rt_go,
    input  logic              rt_free
);
    logic [PW-1:0]     wr_gray, wr_gray_s, prot_gray, prot_gray_s, wr_used;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              we, re, mark_on;
    side_flags_t       wflags, rflags;

    xfifo_wr_side #(.AW(ADDR_W), .THRESH0(DEF_OFFSET)) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en),
        .af_load(af_load), .af_value(af_value),
        .prot_gray_s(prot_gray_s),
        .mem_we(we), .mem_addr(waddr), .wr_gray(wr_gray),
        .used(wr_used), .flags(wflags)
    );

    xfifo_rd_side #(.AW(ADDR_W), .THRESH0(DEF_OFFSET)) u_rd (
        .clk(rd_clk), .rst(rst), .rd_en(rd_en),
        .rt_mark(rt_mark), .rt_go(rt_go), .rt_free(rt_free),
        .ae_load(ae_load), .ae_value(ae_value),
        .wr_gray_s(wr_gray_s),
        .mem_re(re), .mem_addr(raddr), .prot_gray(prot_gray),
        .mark_on(mark_on), .flags(rflags)
    );

    xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rst), .d(wr_gray), .q(wr_gray_s)
    );

    xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(rst), .d(prot_gray), .q(prot_gray_s)
    );

    xfifo_ram #(.DW(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_data)
    );

    assign in_ready     = wflags.ready;
    assign almost_full  = wflags.almost;
    assign out_ready    = rflags.ready;
    assign almost_empty = rflags.almost;
endmodule

// File: rtl/xfifo_checks.sv
module xfifo_checks #(
    parameter int DW    = 36,
    parameter int DEPTH = 512,
    parameter int PW    = 10
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic          in_ready,
    input logic          out_ready,
    input logic          rd_en,
    input logic          rt_go,
    input logic          mark_on,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] wr_used,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] prot_gray
);
    p_rd_reset_r1: assert property (@(posedge rd_clk) rst |=> !out_ready);

    p_wr_reset_r1: assert property (@(posedge wr_clk) rst |=> !in_ready);

    p_hold_word_r2: assert property (@(posedge rd_clk) disable iff (rst)
        out_ready && !rd_en && !rt_go |=> out_ready && $stable(rd_data));

    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (rst)
        wr_used <= PW'(DEPTH));

    p_replay_dip_r8: assert property (@(posedge rd_clk) disable iff (rst)
        rt_go && mark_on |=> !out_ready);

    p_wr_gray_step_r10: assert property (@(posedge wr_clk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    p_prot_gray_step_r10: assert property (@(posedge rd_clk) disable iff (rst)
        $countones(prot_gray ^ $past(prot_gray)) <= 1);
endmodule

bind dual_clock_fwft_fifo xfifo_checks #(.DW(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_checks (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
    .in_ready(in_ready), .out_ready(out_ready), .rd_en(rd_en),
    .rt_go(rt_go), .mark_on(mark_on), .rd_data(rd_data),
    .wr_used(wr_used), .wr_gray(wr_gray), .prot_gray(prot_gray)
);

// File: tb/test_dual_clock_fwft_fifo.sv
module test_dual_clock_fwft_fifo;
    localparam int DEPTH = 16;
    localparam int PW    = 5;
    localparam int DW    = 36;

    logic wr_clk = 0, rd_clk = 0, rst = 1;
    logic wr_en = 0, rd_en = 0, af_load = 0, ae_load = 0;
    logic rt_mark = 0, rt_go = 0, rt_free = 0;
    logic [DW-1:0] wr_data = '0;
    logic [PW-1:0] af_value = '0, ae_value = '0;
    logic in_ready, almost_full, out_ready, almost_empty;
    logic [DW-1:0] rd_data;

    int checks = 0, failures = 0;
    int ae_th = 8, af_th = 8;
    logic [DW-1:0] model [$];

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dual_clock_fwft_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .DEF_OFFSET(8)) i_dual_clock_fwft_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .af_load(af_load), .af_value(af_value),
        .in_ready(in_ready), .almost_full(almost_full),
        .rd_en(rd_en), .rd_data(rd_data), .out_ready(out_ready),
        .almost_empty(almost_empty), .ae_load(ae_load), .ae_value(ae_value),
        .rt_mark(rt_mark), .rt_go(rt_go), .rt_free(rt_free)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic push_word(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 0;
        model.push_back(d);
    endtask

    task automatic pop_word(input string tag);
        @(negedge rd_clk);
        while (!out_ready) @(negedge rd_clk);
        chk(tag, 64'(rd_data), 64'(model.pop_front()));
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
    endtask

    // n stored words, occ occupied words on the write side
    task automatic flags_chk(input int n, input int occ);
        chk("R5 almost_empty", 64'(almost_empty), 64'(n <= ae_th));
        chk("R6 almost_full", 64'(almost_full), 64'((DEPTH - occ) <= af_th));
        chk("R3 in_ready", 64'(in_ready), 64'(occ < DEPTH));
        chk("R2 out_ready", 64'(out_ready), 64'(n > 0));
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (6) @(negedge rd_clk);
        chk("R1 in_ready in reset", 64'(in_ready), 64'd0);
        chk("R1 out_ready in reset", 64'(out_ready), 64'd0);
        @(negedge wr_clk); rst = 0;
        settle(12);
        chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
        chk("R1 out_ready after reset", 64'(out_ready), 64'd0);
        chk("R1 almost_empty after reset", 64'(almost_empty), 64'd1);
        chk("R1 almost_full after reset", 64'(almost_full), 64'd0);

        // R2 R5 R6: fill sweep
        for (int n = 1; n <= DEPTH; n++) begin
            push_word(36'h100 + 36'(n * 7));
            settle(12);
            flags_chk(n, n);
            chk("R2 presented word", 64'(rd_data), 64'(model[0]));
        end
        // R3: writes while full are dropped
        @(negedge wr_clk); wr_en = 1; wr_data = 36'hDEAD;
        repeat (3) @(negedge wr_clk);
        wr_en = 0;
        settle(12);
        chk("R3 in_ready held low", 64'(in_ready), 64'd0);
        // drain sweep
        for (int n = DEPTH - 1; n >= 0; n--) begin
            pop_word("R2 drain order");
            settle(12);
            flags_chk(n, n);
        end
        chk("R3 dropped word absent", 64'(out_ready), 64'd0);

        // R4: read while empty removes nothing
        @(negedge rd_clk); rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        push_word(36'hA5A5);
        push_word(36'h5A5A);
        settle(12);
        chk("R4 first word kept", 64'(rd_data), 64'h A5A5);
        chk("R4 out_ready", 64'(out_ready), 64'd1);

        // R7: threshold loads, 2 words stored
        for (int k = 0; k <= DEPTH; k++) begin
            @(negedge rd_clk); ae_load = 1; ae_value = PW'(k);
            @(negedge rd_clk); ae_load = 0;
            @(negedge wr_clk); af_load = 1; af_value = PW'(k);
            @(negedge wr_clk); af_load = 0;
            ae_th = k; af_th = k;
            settle(6);
            chk("R7 almost_empty threshold", 64'(almost_empty), 64'(2 <= k));
            chk("R7 almost_full threshold", 64'(almost_full), 64'((DEPTH - 2) <= k));
        end
        @(negedge rd_clk); ae_load = 1; ae_value = 5'd8;
        @(negedge rd_clk); ae_load = 0;
        @(negedge wr_clk); af_load = 1; af_value = 5'd8;
        @(negedge wr_clk); af_load = 0;
        ae_th = 8; af_th = 8;
        pop_word("R2 drain");
        pop_word("R2 drain");
        settle(12);

        // R8: replay from a mark
        for (int i = 0; i < 6; i++) push_word(36'h700 + 36'(i));
        settle(12);
        pop_word("R8 word0");
        @(negedge rd_clk);
        while (!out_ready) @(negedge rd_clk);
        chk("R8 marked word presented", 64'(rd_data), 64'h701);
        rt_mark = 1;
        @(negedge rd_clk); rt_mark = 0;
        pop_word("R8 word1");
        pop_word("R8 word2");
        pop_word("R8 word3");
        @(negedge rd_clk); rt_go = 1;
        @(negedge rd_clk); rt_go = 0;
        chk("R8 out_ready dips", 64'(out_ready), 64'd0);
        model.delete();
        for (int i = 1; i < 6; i++) model.push_back(36'h700 + 36'(i));
        for (int i = 1; i < 6; i++) pop_word("R8 replay order");
        settle(12);
        chk("R8 empty after replay", 64'(out_ready), 64'd0);

        // R9: the held mark keeps 5 words occupied, so 11 more fit
        begin
            int acc = 0;
            for (int i = 0; i < DEPTH + 4; i++) begin
                @(negedge wr_clk);
                if (in_ready) begin
                    push_word(36'h900 + 36'(i));
                    acc++;
                end
            end
            chk("R9 accepted while marked", 64'(acc), 64'(DEPTH - 5));
        end
        settle(12);
        chk("R9 in_ready low while marked", 64'(in_ready), 64'd0);
        chk("R9 almost_full while marked", 64'(almost_full), 64'd1);
        @(negedge rd_clk); rt_free = 1;
        @(negedge rd_clk); rt_free = 0;
        settle(40);
        flags_chk(DEPTH - 5, DEPTH - 5);
        for (int i = 0; i < DEPTH - 5; i++) pop_word("R9 words after release");
        settle(40);
        flags_chk(0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule